// File: doc/BRIEF.md
# Chunked Transpose Address Generator

This block produces the memory addresses needed to write streamed samples into a paged buffer and to read them back in transposed order. Incoming samples arrive one per accepted cycle. Each group of write-chunk samples lands at the start of a fixed-size slot, and any padding gap at the end of a slot is skipped. Once a page is fully written, the read side emits a sequence of chunk requests. Each request carries a start address and a length. Successive chunks step through the page by a stride of several slots. When a step would go past the page end, it folds back and moves one read chunk further inside the blocks.

The buffer holds two pages. The most significant address bit selects the page. While the reader drains one page, the writer fills the other. The writer stalls only when both pages hold unread data. All sizes are fixed at elaboration.

Top module: `xpose_addr_gen`

## Requirements
- R1: The n-th accepted write sample of a page (block b = n / WR_CHUNK, index j = n mod WR_CHUNK) gets the in-page address b*(WR_CHUNK+GAP)+j.
- R2: No accepted write address has an in-page offset whose remainder modulo the slot size (WR_CHUNK+GAP) is WR_CHUNK or more.
- R3: Read chunk k of a page starts at boff+coff and has length RD_CHUNK. Both offsets begin at 0. After each chunk, boff grows by RD_INTERVAL*slot. If the result is at least the page size, the page size is subtracted and coff grows by RD_CHUNK.
- R4: The first read chunk of every page starts at in-page address 0, whatever the previous page ended on.
- R5: rd_last_o is high together with rd_valid_o exactly on chunk NUM_BLOCKS*RD_PER_BLK-1 of a page, and low otherwise.
- R6: rd_valid_o is high only while at least one page has been completely written and not yet completely read.
- R7: The address MSB (bit LW, the page select) is 0 for even-numbered pages and 1 for odd-numbered pages, on both sides. wr_ready_o is low exactly when two written pages are waiting to be read.
- R8: While rd_valid_o is high and rd_ready_i is low, rd_addr_o and rd_last_o keep their values into the next cycle.
- R9: After reset, wr_ready_o is 1, rd_valid_o is 0 and wr_addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Sample present this cycle |
| wr_ready_o | output | 1 | Writer can accept a sample |
| wr_addr_o | output | LW+1 | Address for the current sample; the MSB selects the page |
| rd_valid_o | output | 1 | Read chunk request valid |
| rd_ready_i | input | 1 | Read request taken |
| rd_addr_o | output | LW+1 | Chunk start address; the MSB selects the page |
| rd_len_o | output | LENW | Chunk length in samples |
| rd_last_o | output | 1 | Final chunk of the page |

## Verification
A corrupted slot base or sample counter shows on wr_addr_o at the very next accepted sample. A wrongly wrapped block offset or chunk offset moves rd_addr_o on the next chunk after the fault. A stuck page flag shows up within one page. Either rd_valid_o rises before the page has been written, or wr_ready_o stays low after the reader frees a page. The bench compares every handshake against its own model of both counters and both pages. It also compares the ready and valid levels every cycle.

// File: rtl/xpose_pkg.sv
package xpose_pkg;
  typedef enum logic {PAGE_A = 1'b0, PAGE_B = 1'b1} page_e;

  function automatic page_e flip(page_e p);
    return (p == PAGE_A) ? PAGE_B : PAGE_A;
  endfunction
endpackage

// File: rtl/xpose_page_flags.sv
module xpose_page_flags
  import xpose_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  page_e      set_page_i,
  input  logic       clr_i,
  input  page_e      clr_page_i,
  output logic [1:0] full_o
);
  for (genvar g = 0; g < 2; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) full_o[g] <= 1'b0;
      else if (set_i && (logic'(set_page_i) == 1'(g))) full_o[g] <= 1'b1;
      else if (clr_i && (logic'(clr_page_i) == 1'(g))) full_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/xpose_wr_ctrl.sv
module xpose_wr_ctrl
  import xpose_pkg::*;
#(
  parameter int WR_CHUNK   = 256,
  parameter int GAP        = 0,
  parameter int NUM_BLOCKS = 32,
  parameter int LW         = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  output page_e         page_o,
  output logic [LW-1:0] addr_o,
  output logic          done_o
);
  localparam int SLOT = WR_CHUNK + GAP;
  localparam int JW   = $clog2(WR_CHUNK + 1);
  localparam int BW   = $clog2(NUM_BLOCKS + 1);

  logic [JW-1:0] j_q;
  logic [BW-1:0] blk_q;
  logic [LW-1:0] base_q;
  page_e         page_q;
  logic          last_j, last_blk;

  assign last_j   = (j_q == JW'(WR_CHUNK - 1));
  assign last_blk = (blk_q == BW'(NUM_BLOCKS - 1));
  assign addr_o   = base_q + LW'(j_q);
  assign done_o   = fire_i & last_j & last_blk;
  assign page_o   = page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      j_q    <= '0;
      blk_q  <= '0;
      base_q <= '0;
      page_q <= PAGE_A;
    end else if (fire_i) begin
      if (last_j) begin
        j_q <= '0;
        if (last_blk) begin
          blk_q  <= '0;
          base_q <= '0;
          page_q <= flip(page_q);
        end else begin
          blk_q  <= blk_q + 1'b1;
          base_q <= base_q + LW'(SLOT);  // skip the gap
        end
      end else begin
        j_q <= j_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/xpose_rd_ctrl.sv
module xpose_rd_ctrl
  import xpose_pkg::*;
#(
  parameter int RD_CHUNK    = 32,
  parameter int RD_PER_BLK  = 8,
  parameter int NUM_BLOCKS  = 32,
  parameter int RD_INTERVAL = 32,
  parameter int SLOT        = 256,
  parameter int PAGE        = 8192,
  parameter int LW          = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  output page_e         page_o,
  output logic [LW-1:0] start_o,
  output logic          last_o,
  output logic          done_o
);
  localparam int STRIDE = RD_INTERVAL * SLOT;
  localparam int NRD    = NUM_BLOCKS * RD_PER_BLK;
  localparam int CW     = $clog2(NRD + 1);
  localparam int XW     = $clog2(PAGE + STRIDE + 1) + 1;

  logic [XW-1:0] bo_q, co_q, bo_nx, sum;
  logic [CW-1:0] cnt_q;
  page_e         page_q;
  logic          wrap;

  assign bo_nx   = bo_q + XW'(STRIDE);
  assign wrap    = (bo_nx >= XW'(PAGE));
  assign sum     = bo_q + co_q;
  assign start_o = sum[LW-1:0];
  assign last_o  = (cnt_q == CW'(NRD - 1));
  assign done_o  = fire_i & last_o;
  assign page_o  = page_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bo_q   <= '0;
      co_q   <= '0;
      cnt_q  <= '0;
      page_q <= PAGE_A;
    end else if (fire_i) begin
      if (last_o) begin
        bo_q   <= '0;
        co_q   <= '0;
        cnt_q  <= '0;
        page_q <= flip(page_q);
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (wrap) begin
          bo_q <= bo_nx - XW'(PAGE);
          co_q <= co_q + XW'(RD_CHUNK);
        end else begin
          bo_q <= bo_nx;
        end
      end
    end
  end
endmodule

// File: rtl/xpose_addr_gen.sv
module xpose_addr_gen
  import xpose_pkg::*;
#(
  parameter int WR_CHUNK    = 256,
  parameter int GAP         = 0,
  parameter int NUM_BLOCKS  = 32,
  parameter int RD_CHUNK    = 32,
  parameter int RD_PER_BLK  = 8,
  parameter int RD_INTERVAL = 32,
  localparam int SLOT       = WR_CHUNK + GAP,
  localparam int PAGE       = SLOT * NUM_BLOCKS,
  localparam int LW         = $clog2(PAGE),
  localparam int AW         = LW + 1,
  localparam int LENW       = $clog2(RD_CHUNK + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_valid_i,
  output logic            wr_ready_o,
  output logic [AW-1:0]   wr_addr_o,
  output logic            rd_valid_o,
  input  logic            rd_ready_i,
  output logic [AW-1:0]   rd_addr_o,
  output logic [LENW-1:0] rd_len_o,
  output logic            rd_last_o
);
  page_e         wr_page, rd_page;
  logic [LW-1:0] wr_loc, rd_loc;
  logic          wr_fire, rd_fire, wr_done, rd_done, rd_last;
  logic [1:0]    full;

  assign wr_ready_o = ~full[wr_page];
  assign wr_fire    = wr_valid_i & wr_ready_o;
  assign rd_valid_o = full[rd_page];
  assign rd_fire    = rd_valid_o & rd_ready_i;
  assign wr_addr_o  = {logic'(wr_page), wr_loc};
  assign rd_addr_o  = {logic'(rd_page), rd_loc};
  assign rd_len_o   = LENW'(RD_CHUNK);
  assign rd_last_o  = rd_valid_o & rd_last;

  xpose_wr_ctrl #(
    .WR_CHUNK(WR_CHUNK), .GAP(GAP), .NUM_BLOCKS(NUM_BLOCKS), .LW(LW)
  ) u_wr (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(wr_fire),
    .page_o(wr_page), .addr_o(wr_loc), .done_o(wr_done)
  );

  xpose_rd_ctrl #(
    .RD_CHUNK(RD_CHUNK), .RD_PER_BLK(RD_PER_BLK), .NUM_BLOCKS(NUM_BLOCKS),
    .RD_INTERVAL(RD_INTERVAL), .SLOT(SLOT), .PAGE(PAGE), .LW(LW)
  ) u_rd (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(rd_fire),
    .page_o(rd_page), .start_o(rd_loc), .last_o(rd_last), .done_o(rd_done)
  );

  xpose_page_flags u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .set_i(wr_done), .set_page_i(wr_page),
    .clr_i(rd_done), .clr_page_i(rd_page),
    .full_o(full)
  );
endmodule

// File: rtl/xpose_addr_gen_chk.sv
module xpose_addr_gen_chk #(
  parameter int WR_CHUNK   = 256,
  parameter int GAP        = 0,
  parameter int NUM_BLOCKS = 32,
  parameter int AW         = 14,
  parameter int LENW       = 6
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_valid_i,
  input logic            wr_ready_o,
  input logic [AW-1:0]   wr_addr_o,
  input logic            rd_valid_o,
  input logic            rd_ready_i,
  input logic [AW-1:0]   rd_addr_o,
  input logic [LENW-1:0] rd_len_o,
  input logic            rd_last_o
);
  localparam int LW = AW - 1;
  localparam logic [LW-1:0] SLOT_L = LW'(WR_CHUNK + GAP);
  localparam logic [LW-1:0] CHK_L  = LW'(WR_CHUNK);

  logic wr_fire, rd_fire;
  assign wr_fire = wr_valid_i & wr_ready_o;
  assign rd_fire = rd_valid_o & rd_ready_i;

  p_gap_skip_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire |-> ((wr_addr_o[LW-1:0] % SLOT_L) < CHK_L));

  p_wr_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_fire && ((wr_addr_o[LW-1:0] % SLOT_L) != CHK_L - 1'b1))
      |=> (wr_addr_o == $past(wr_addr_o) + 1'b1));

  p_rd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && !rd_ready_i)
      |=> (rd_valid_o && $stable(rd_addr_o) && $stable(rd_last_o)));

  p_last_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_last_o |-> rd_valid_o);

  p_page_restart_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_fire && rd_last_o)
      |=> ((rd_addr_o[LW-1:0] == '0) && (rd_addr_o[LW] != $past(rd_addr_o[LW]))));

  p_no_overrun_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && (wr_addr_o[LW] == rd_addr_o[LW])) |-> !wr_ready_o);
endmodule

bind xpose_addr_gen xpose_addr_gen_chk #(
  .WR_CHUNK(WR_CHUNK), .GAP(GAP), .NUM_BLOCKS(NUM_BLOCKS), .AW(AW), .LENW(LENW)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_valid_i(wr_valid_i), .wr_ready_o(wr_ready_o),
  .wr_addr_o(wr_addr_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
  .rd_addr_o(rd_addr_o), .rd_len_o(rd_len_o), .rd_last_o(rd_last_o)
);

// File: tb/sim_xpose_addr_gen.sv
`timescale 1ns/1ps
module sim_xpose_addr_gen;
  localparam int WR_CHUNK = 8, GAP = 2, NB = 6, RD_CHUNK = 2, RPB = 4, RINT = 3;
  localparam int SLOT = WR_CHUNK + GAP, PAGE = SLOT * NB, STRIDE = RINT * SLOT;
  localparam int NRD = NB * RPB, NWR = WR_CHUNK * NB;
  localparam int LW = $clog2(PAGE), AW = LW + 1, LENW = $clog2(RD_CHUNK + 1);

  logic clk_i = 1'b0, rst_ni = 1'b0, wr_valid_i = 1'b0, rd_ready_i = 1'b0;
  logic wr_ready_o, rd_valid_o, rd_last_o;
  logic [AW-1:0] wr_addr_o, rd_addr_o;
  logic [LENW-1:0] rd_len_o;

  always #5 clk_i = ~clk_i;

  xpose_addr_gen #(.WR_CHUNK(WR_CHUNK), .GAP(GAP), .NUM_BLOCKS(NB), .RD_CHUNK(RD_CHUNK),
                   .RD_PER_BLK(RPB), .RD_INTERVAL(RINT)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  int wr_n = 0, pg_w = 0, rd_k = 0, pg_r = 0;
  logic hold_prev = 1'b0;
  logic [AW-1:0] hold_addr;

  function automatic int rd_start(int k);
    int bo = 0, co = 0;
    for (int i = 0; i < k; i++) begin
      bo += STRIDE;
      if (bo >= PAGE) begin bo -= PAGE; co += RD_CHUNK; end
    end
    return bo + co;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(logic wv, logic rr);
    @(negedge clk_i);
    wr_valid_i = wv; rd_ready_i = rr;
    #1;
    chk("R7 wr_ready", int'(wr_ready_o), int'((pg_w - pg_r) < 2));
    chk("R6 rd_valid", int'(rd_valid_o), int'(pg_w > pg_r));
    if (hold_prev) chk("R8 hold", int'(rd_addr_o), int'(hold_addr));
    if (wr_valid_i && wr_ready_o) begin
      chk("R1 wr_addr", int'(wr_addr_o),
          ((pg_w % 2) << LW) + (wr_n / WR_CHUNK) * SLOT + (wr_n % WR_CHUNK));
      wr_n++;
      if (wr_n == NWR) begin wr_n = 0; pg_w++; end
    end
    if (rd_valid_o) begin
      chk(rd_k == 0 ? "R4 rd_first" : "R3 rd_addr", int'(rd_addr_o),
          ((pg_r % 2) << LW) + rd_start(rd_k));
      chk("R3 rd_len", int'(rd_len_o), RD_CHUNK);
      chk("R5 rd_last", int'(rd_last_o), int'(rd_k == NRD - 1));
      if (rd_ready_i) begin
        rd_k++;
        if (rd_k == NRD) begin rd_k = 0; pg_r++; end
      end
    end else chk("R5 last_idle", int'(rd_last_o), 0);
    hold_prev = rd_valid_o && !rd_ready_i;
    hold_addr = rd_addr_o;
  endtask

  initial begin
    void'($urandom(32'd1234));
    #12;
    chk("R9 wr_ready", int'(wr_ready_o), 1);
    chk("R9 rd_valid", int'(rd_valid_o), 0);
    chk("R9 wr_addr", int'(wr_addr_o), 0);
    rst_ni = 1'b1;
    // fill both pages with reader stalled
    for (int i = 0; i < 2 * NWR + 6; i++) cyc(1'b1, 1'b0);
    chk("R7 both_full", int'(wr_ready_o), 0);
    // drain with random ready
    for (int i = 0; i < 200; i++) cyc(1'b0, 1'($urandom % 3 != 0));
    // mixed random traffic
    for (int i = 0; i < 4000; i++) cyc(1'($urandom % 4 != 0), 1'($urandom % 3 != 0));
    for (int i = 0; i < 300; i++) cyc(1'b0, 1'b1);
    chk("R6 drained", int'(rd_valid_o), 0);
    chk("R2 pages", int'(pg_w > 10), 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule